// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital control for a 12-bit successive-approximation converter. The converter is built on a switched, binary-weighted capacitor array. A single-cycle start request launches a conversion of fixed length. For the first three cycles every capacitor's switchable terminal sits on the analog input, so the comparator can auto-balance. After that the sequencer resolves one bit per cycle, from the most significant down. For each bit it puts that bit's capacitor on the positive reference and reads the single-bit comparator at the end of the cycle.

Every capacitor has its own 2-bit switch select. The comparator result fixes whether a capacitor that has already been decided stays on the positive reference or drops to the negative one. When the last bit has been decided, a one-cycle done pulse marks the point where the 12-bit result register takes the new code. The capacitor array, the comparator and the references are analog parts outside this block.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After a conversion, the result equals the code that an ideal comparator gives for the sampled input. Bit i of the result is the decision for the capacitor of weight 2^i.
- R2: A start sampled while idle makes busy high for exactly 15 consecutive cycles, beginning in the next cycle. Call these conversion cycles 1 to 15.
- R3: In conversion cycles 1 to 3, every switch select is 00 (analog input).
- R4: In conversion cycle 4, the select of capacitor 11 (the MSB) is 01 and the select of every other capacitor is 10.
- R5: The comparator is captured at the end of each bit cycle. In every later cycle of the same conversion, the tested capacitor's select is 01 if the captured value was high and 10 if it was low.
- R6: Conversion cycle c, for c from 4 to 15, tests bit 15-c. That capacitor's select is 01 and every lower capacitor's select is 10.
- R7: Select encoding is 00 = analog input, 01 = positive reference, 10 = negative reference. The value 11 never appears, and all selects are 00 whenever the sequencer is not in a bit cycle.
- R8: A start that arrives while busy is high is ignored. The running conversion still ends on schedule, and no second conversion follows.
- R9: In the cycle after conversion cycle 15, busy is low and done is high for exactly one cycle. The new result is visible in that same cycle.
- R10: A synchronous reset, including one taken mid-conversion, leaves busy and done low, all selects at 00 and the result at zero.
- R11: The result holds its value until the next conversion completes. This includes the whole time a later conversion is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle conversion request |
| comp | input | 1 | Comparator output, high when the input exceeds the trial level |
| busy | output | 1 | High during the 15 conversion cycles |
| done | output | 1 | One-cycle pulse when the result updates |
| result | output | 12 | Last completed conversion code |
| sw_sel | output | 24 | Per-capacitor switch selects, capacitor i on bits [2i+1:2i] |

## Verification
The hardest situations to reach are the ones where a start or a reset lands in the middle of the bit-decision phase. Both depend on an exact cycle offset inside the fixed schedule. The bench drives each conversion cycle by cycle from a task, so it can raise start or reset at a chosen conversion cycle. A behavioural comparator in the bench turns the 01 selects back into a trial level. This means every switch pattern the bench checks is the one that actually produced the decisions.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    SEL_VIN  = 2'b00,
    SEL_REFP = 2'b01,
    SEL_REFN = 2'b10
  } cap_sel_e;

  // Bit index tested in conversion cycle cyc (valid only in bit cycles).
  function automatic int unsigned bit_of_cycle(input int unsigned cyc,
                                               input int unsigned nbal,
                                               input int unsigned nbits);
    return nbits + nbal - cyc;
  endfunction

  // Switch for capacitor idx while bit tbit is on trial.
  function automatic cap_sel_e cap_select(input int unsigned idx,
                                          input int unsigned tbit,
                                          input logic        decided,
                                          input logic        trial_on);
    if (!trial_on)       return SEL_VIN;
    else if (idx > tbit) return decided ? SEL_REFP : SEL_REFN;
    else if (idx == tbit) return SEL_REFP;
    else                 return SEL_REFN;
  endfunction

endpackage

// File: rtl/sar_seq_timer.sv
module sar_seq_timer #(
  parameter int NBITS = 12,
  parameter int NBAL  = 3,
  localparam int NCYC = NBITS + NBAL,
  localparam int CW   = $clog2(NCYC + 1),
  localparam int IW   = $clog2(NBITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] cyc_cnt,
  output logic          accept,
  output logic          bal_phase,
  output logic          bit_phase,
  output logic          last_cycle,
  output logic [IW-1:0] bidx
);
  import sar_seq_pkg::*;

  localparam logic [CW-1:0] LAST = CW'(NCYC);
  localparam logic [CW-1:0] BALN = CW'(NBAL);

  assign accept     = start && !busy;
  assign bal_phase  = busy && (cyc_cnt <= BALN);
  assign bit_phase  = busy && (cyc_cnt > BALN);
  assign last_cycle = busy && (cyc_cnt == LAST);
  assign bidx       = IW'(bit_of_cycle(32'(cyc_cnt), NBAL, NBITS));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      cyc_cnt <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        cyc_cnt <= CW'(1);
      end else if (last_cycle) begin
        busy    <= 1'b0;
        done    <= 1'b1;
        cyc_cnt <= '0;
      end else if (busy) begin
        cyc_cnt <= cyc_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sar_seq_reg.sv
module sar_seq_reg #(
  parameter int NBITS = 12,
  localparam int IW   = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             bit_phase,
  input  logic             last_cycle,
  input  logic [IW-1:0]    bidx,
  input  logic             comp,
  output logic [NBITS-1:0] dec,
  output logic [NBITS-1:0] result
);
  logic [NBITS-1:0] dec_nx;

  always_comb begin
    dec_nx = dec;
    if (bit_phase) dec_nx[bidx] = comp;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec    <= '0;
      result <= '0;
    end else begin
      if (accept)         dec <= '0;
      else if (bit_phase) dec <= dec_nx;
      if (last_cycle)     result <= dec_nx;
    end
  end
endmodule

// File: rtl/sar_seq_swdrv.sv
module sar_seq_swdrv #(
  parameter int NBITS = 12,
  localparam int IW   = $clog2(NBITS)
) (
  input  logic               bit_phase,
  input  logic [IW-1:0]      bidx,
  input  logic [NBITS-1:0]   dec,
  output logic [2*NBITS-1:0] sw_sel
);
  import sar_seq_pkg::*;

  for (genvar i = 0; i < NBITS; i++) begin : g_cap
    assign sw_sel[2*i +: 2] = cap_select(i, 32'(bidx), dec[i], bit_phase);
  end
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl #(
  parameter int NBITS = 12,
  parameter int NBAL  = 3,
  localparam int NCYC = NBITS + NBAL,
  localparam int CW   = $clog2(NCYC + 1),
  localparam int IW   = $clog2(NBITS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               comp,
  output logic               busy,
  output logic               done,
  output logic [NBITS-1:0]   result,
  output logic [2*NBITS-1:0] sw_sel
);
  logic [CW-1:0]    cyc_cnt;
  logic             accept;
  logic             bal_phase;
  logic             bit_phase;
  logic             last_cycle;
  logic [IW-1:0]    bidx;
  logic [NBITS-1:0] dec;

  sar_seq_timer #(.NBITS(NBITS), .NBAL(NBAL)) u_timer (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .cyc_cnt(cyc_cnt), .accept(accept), .bal_phase(bal_phase),
    .bit_phase(bit_phase), .last_cycle(last_cycle), .bidx(bidx)
  );

  sar_seq_reg #(.NBITS(NBITS)) u_reg (
    .clk(clk), .rst(rst), .accept(accept), .bit_phase(bit_phase),
    .last_cycle(last_cycle), .bidx(bidx), .comp(comp), .dec(dec),
    .result(result)
  );

  sar_seq_swdrv #(.NBITS(NBITS)) u_swdrv (
    .bit_phase(bit_phase), .bidx(bidx), .dec(dec), .sw_sel(sw_sel)
  );
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int NBITS = 12,
  parameter int NBAL  = 3,
  localparam int NCYC = NBITS + NBAL,
  localparam int CW   = $clog2(NCYC + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic [NBITS-1:0]   result,
  input logic [2*NBITS-1:0] sw_sel,
  input logic               bal_phase,
  input logic               bit_phase,
  input logic               last_cycle,
  input logic [CW-1:0]      cyc_cnt
);
  logic [NBITS-1:0] bad_code;
  for (genvar i = 0; i < NBITS; i++) begin : g_bad
    assign bad_code[i] = &sw_sel[2*i +: 2];
  end

  p_no_code11_r7: assert property (@(posedge clk) disable iff (rst)
    bad_code == '0);

  p_idle_vin_r7: assert property (@(posedge clk) disable iff (rst)
    !bit_phase |-> sw_sel == '0);

  p_bal_vin_r3: assert property (@(posedge clk) disable iff (rst)
    bal_phase |-> sw_sel == '0);

  p_launch_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && cyc_cnt == CW'(1)));

  p_finish_r9: assert property (@(posedge clk) disable iff (rst)
    last_cycle |=> (!busy && done));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !last_cycle) |=> (busy && cyc_cnt == $past(cyc_cnt) + 1'b1));

  p_result_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !last_cycle |=> $stable(result));
endmodule

bind sar_seq_ctrl sar_seq_chk #(.NBITS(NBITS), .NBAL(NBAL)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .result(result), .sw_sel(sw_sel), .bal_phase(bal_phase),
  .bit_phase(bit_phase), .last_cycle(last_cycle), .cyc_cnt(cyc_cnt)
);

// File: tb/sar_seq_ctrl_tb.sv
module sar_seq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        comp;
  logic        busy, done;
  logic [11:0] result;
  logic [23:0] sw_sel;
  int          vin = 0;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  sar_seq_ctrl u_dut (
    .clk(clk), .rst(rst), .start(start), .comp(comp),
    .busy(busy), .done(done), .result(result), .sw_sel(sw_sel)
  );

  // Analog model: trial level is the weight sum of capacitors on the positive reference.
  function automatic int trial_level(input logic [23:0] s);
    int lvl = 0;
    for (int i = 0; i < 12; i++) if (s[2*i +: 2] == 2'b01) lvl += (1 << i);
    return lvl;
  endfunction
  assign comp = (vin >= trial_level(sw_sel));

  // Expected selects in conversion cycle c for final code
  function automatic logic [23:0] want_sw(input int c, input logic [11:0] code);
    logic [23:0] s = '0;
    if (c >= 4 && c <= 15) begin
      int tb_bit = 15 - c;
      for (int i = 0; i < 12; i++) begin
        if (i == tb_bit)     s[2*i +: 2] = 2'b01;
        else if (i < tb_bit) s[2*i +: 2] = 2'b10;
        else                 s[2*i +: 2] = code[i] ? 2'b01 : 2'b10;
      end
    end
    return s;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One conversion; extra_at/rst_at: conversion cycle in which to raise start/rst (0 = none)
  task automatic convert(input int v, input logic [11:0] exp, input int extra_at,
                         input logic [11:0] prev);
    vin = v;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int c = 1; c <= 15; c++) begin
      chk(busy == 1'b1 && done == 1'b0, "R2 busy in conversion", {busy, done}, 2'b10);
      if (c <= 3)
        chk(sw_sel == '0, "R3 balance selects", sw_sel, 0);
      else if (c == 4)
        chk(sw_sel == want_sw(c, exp), "R4 msb trial", sw_sel, want_sw(c, exp));
      else
        chk(sw_sel == want_sw(c, exp), "R5 R6 bit trial", sw_sel, want_sw(c, exp));
      if (c == 10) chk(result == prev, "R11 hold during run", result, prev);
      if (c == extra_at) start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    chk(busy == 1'b0 && done == 1'b1, "R9 done cycle", {busy, done}, 2'b01);
    chk(result == exp, "R1 result", result, exp);
    chk(sw_sel == '0, "R7 idle selects", sw_sel, 0);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R8 R9 no repeat", {busy, done}, 0);
  endtask

  localparam logic [23:0] VECS [8] = '{
    {12'd0,    12'h000}, {12'd4095, 12'hFFF}, {12'd2048, 12'h800},
    {12'd2047, 12'h7FF}, {12'd1,    12'h001}, {12'd2730, 12'hAAA},
    {12'd1365, 12'h555}, {12'd1234, 12'h4D2}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] last = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(busy == 0 && done == 0, "R10 reset flags", {busy, done}, 0);
    chk(result == '0, "R10 reset result", result, 0);
    chk(sw_sel == '0, "R10 reset selects", sw_sel, 0);

    foreach (VECS[k]) begin
      convert(int'(VECS[k][23:12]), VECS[k][11:0], 0, last);
      last = VECS[k][11:0];
    end

    // R8: start mid conversion and on the final bit cycle
    convert(3000, 12'd3000, 7, last);
    convert(500, 12'd500, 15, 12'd3000);
    last = 12'd500;

    // R11: result stays while input changes and sequencer idles
    vin = 4000;
    repeat (20) @(negedge clk);
    chk(result == last, "R11 hold while idle", result, last);

    // R10: reset in the middle of the bit phase
    vin = 3333;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (7) @(negedge clk);
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk(busy == 0 && done == 0, "R10 mid reset flags", {busy, done}, 0);
    chk(sw_sel == '0, "R10 mid reset selects", sw_sel, 0);
    chk(result == '0, "R10 mid reset result", result, 0);
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R10 stays idle", {busy, done}, 0);

    convert(3333, 12'd3333, 0, 12'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule